// File: doc/BRIEF.md
# Multi-Lane Link Test Pattern Generator

This block produces 32-bit symbol words for each lane of a four-lane serial display link. A global mode chooses what goes out on every lane. The first option passes through the active link data supplied by the upstream encoder. The next two send one of two fixed training placeholder words. The last option is test-pattern mode, in which each lane runs its own generator.

In test-pattern mode, each lane picks its own source: either training placeholder, a PRBS of selectable order, a 264-bit programmable repeating word, or a square wave of programmable width. The lane-count field decides which lanes are live. Lanes beyond that count always output zero.

All configuration goes through a simple write port with an address and a 32-bit data word. Any write restarts every generator, so a new setting always begins from the start of its sequence.

Top module: `link_pattern_gen`

## Requirements
- R1: While `rst_ni` is low, all lane outputs are zero. Reset leaves mode 0 (active data), the lane-count field at 0, every source select at 0 and every order select at 0, square width 0, and the custom pattern all zero.
- R2: Address 0 holds the control register. Bits [1:0] are the mode: 0 active data, 1 training word A, 2 training word B, 3 test pattern. Bits [5:4] are the lane count: 0 gives one lane, 1 gives two lanes, 3 gives four lanes. Lane l is live when l is not above the field value.
- R3: In mode 0, each live lane outputs its 32-bit slice of `link_data_i` (lane l at bits [32l+31:32l]), one clock after it is presented.
- R4: In mode 1, every live lane outputs 32'h55555555. In mode 2, every live lane outputs 32'h3C3C3C3C.
- R5: Address 1 holds the per-lane selects. Bits [3l+2:3l] are the source of lane l: 0 word A, 1 word B, 2 PRBS, 3 custom, 4 square. Codes 5 to 7 give zero. Bits [12+3l+2:12+3l] are the PRBS order of lane l: 0 to 5 select PRBS7, 9, 11, 15, 23 and 31. Codes 6 and 7 act as PRBS7. These selects only matter in mode 3.
- R6: The PRBS is a Fibonacci shift register of n bits, seeded to all ones. Each step computes fb = s[n-1] xor s[t-1], then shifts s left with fb entering at bit 0. The (n,t) pairs are (7,6), (9,5), (11,9), (15,14), (23,18) and (31,28). Thirty-two steps run per clock, and the fb of step b goes to output bit b.
- R7: Addresses 16 to 26 load custom chunks 0 to 10 from data bits [23:0]. Within a chunk, byte 3i sits at bits 7:0, byte 3i+1 at 15:8 and byte 3i+2 at 23:16. Pattern bit 24i+k is chunk i bit k. Output word n after a restart carries pattern bit (32n+b) mod 264 in bit b.
- R8: Address 2 bits [7:0] set the square width w, where 0 acts as 1. The square source outputs w words of all ones, then w words of all zeros, and repeats.
- R9: Any configuration write restarts every lane generator at that clock edge. Word 0 of the new sequence appears on the output after the next rising edge.
- R10: Lanes that are not live output zero in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| link_data_i | input | 128 | Active link symbols, lane l at [32l+31:32l] |
| lane_data_o | output | 128 | Registered lane symbols, lane l at [32l+31:32l] |

## Verification
A wrong generator state shows directly in the lane word one clock after it arises. A corrupted PRBS register, a misplaced rotation of the custom register, or a square counter that is off by one gives a wrong 32-bit word at the next sample. A restart that did not happen shows as a first word after a write that differs from the sequence start. The PRBS checks begin at word 0, after a write. The custom check runs past the 264-bit wrap so that a missing or misplaced residue is caught at word 8. The lane-enable and bad-source checks look at the output word right after the setting takes effect.

// File: rtl/link_pg_pkg.sv
package link_pg_pkg;
  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'd0,
    MODE_TRN_A  = 2'd1,
    MODE_TRN_B  = 2'd2,
    MODE_TEST   = 2'd3
  } mode_e;

  localparam logic [2:0] SRC_TRN_A  = 3'd0;
  localparam logic [2:0] SRC_TRN_B  = 3'd1;
  localparam logic [2:0] SRC_PRBS   = 3'd2;
  localparam logic [2:0] SRC_CUSTOM = 3'd3;
  localparam logic [2:0] SRC_SQUARE = 3'd4;

  localparam logic [31:0] TRN_A_WORD = 32'h5555_5555;
  localparam logic [31:0] TRN_B_WORD = 32'h3C3C_3C3C;

  // {length-1, tap-1}
  function automatic logic [9:0] prbs_taps(input logic [2:0] ord);
    case (ord)
      3'd1:    return {5'd8,  5'd4};
      3'd2:    return {5'd10, 5'd8};
      3'd3:    return {5'd14, 5'd13};
      3'd4:    return {5'd22, 5'd17};
      3'd5:    return {5'd30, 5'd27};
      default: return {5'd6,  5'd5};
    endcase
  endfunction
endpackage

// File: rtl/link_pg_cfg.sv
module link_pg_cfg #(
  parameter int LANES    = 4,
  parameter int AW       = 5,
  parameter int DW       = 32,
  parameter int CHUNKS   = 11,
  parameter int CHUNK_W  = 24,
  parameter int SQ_W     = 8,
  parameter int CUST_BASE = 16,
  localparam int SEL_W   = 3 * LANES,
  localparam int PAT_W   = CHUNKS * CHUNK_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [1:0]         mode_o,
  output logic [1:0]         lane_cnt_o,
  output logic [SEL_W-1:0]   src_o,
  output logic [SEL_W-1:0]   ord_o,
  output logic [SQ_W-1:0]    width_o,
  output logic [PAT_W-1:0]   custom_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o     <= '0;
      lane_cnt_o <= '0;
      src_o      <= '0;
      ord_o      <= '0;
      width_o    <= '0;
      custom_o   <= '0;
    end else if (we_i) begin
      if (addr_i == AW'(0)) begin
        mode_o     <= wdata_i[1:0];
        lane_cnt_o <= wdata_i[5:4];
      end
      if (addr_i == AW'(1)) begin
        src_o <= wdata_i[SEL_W-1:0];
        ord_o <= wdata_i[2*SEL_W-1:SEL_W];
      end
      if (addr_i == AW'(2)) width_o <= wdata_i[SQ_W-1:0];
      for (int i = 0; i < CHUNKS; i++)
        if (addr_i == AW'(CUST_BASE + i))
          custom_o[i*CHUNK_W +: CHUNK_W] <= wdata_i[CHUNK_W-1:0];
    end
  end
endmodule

// File: rtl/link_pg_lane.sv
module link_pg_lane
  import link_pg_pkg::*;
#(
  parameter int W     = 32,
  parameter int PAT_W = 264,
  parameter int SQ_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [2:0]       src_i,
  input  logic [2:0]       ord_i,
  input  logic [SQ_W-1:0]  width_i,
  input  logic [PAT_W-1:0] custom_i,
  output logic [W-1:0]     word_o
);
  logic [30:0]     lfsr_q, lfsr_nxt;
  logic [W-1:0]    prbs_word;
  logic [PAT_W-1:0] pat_q;
  logic [SQ_W:0]   sq_cnt_q, sq_lim;
  logic [9:0]      taps;

  assign taps = prbs_taps(ord_i);

  always_comb begin
    logic [30:0] s;
    logic        fb;
    s = lfsr_q;
    prbs_word = '0;
    for (int b = 0; b < W; b++) begin
      fb = s[taps[9:5]] ^ s[taps[4:0]];
      prbs_word[b] = fb;
      s = {s[29:0], fb};
    end
    lfsr_nxt = s;
  end

  assign sq_lim = (width_i == '0) ? (SQ_W+1)'(1) : {1'b0, width_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q   <= '1;
      pat_q    <= '0;
      sq_cnt_q <= '0;
    end else if (restart_i) begin
      lfsr_q   <= '1;
      pat_q    <= custom_i;
      sq_cnt_q <= '0;
    end else begin
      lfsr_q   <= lfsr_nxt;
      pat_q    <= {pat_q[W-1:0], pat_q[PAT_W-1:W]};
      sq_cnt_q <= (sq_cnt_q >= (sq_lim << 1) - 1'b1) ? '0 : sq_cnt_q + 1'b1;
    end
  end

  always_comb begin
    case (src_i)
      SRC_TRN_A:  word_o = TRN_A_WORD;
      SRC_TRN_B:  word_o = TRN_B_WORD;
      SRC_PRBS:   word_o = prbs_word;
      SRC_CUSTOM: word_o = pat_q[W-1:0];
      SRC_SQUARE: word_o = (sq_cnt_q < sq_lim) ? '1 : '0;
      default:    word_o = '0;
    endcase
  end
endmodule

// File: rtl/link_pattern_gen.sv
module link_pattern_gen
  import link_pg_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int W       = 32,
  parameter int AW      = 5,
  parameter int CHUNKS  = 11,
  parameter int CHUNK_W = 24,
  parameter int SQ_W    = 8,
  localparam int SEL_W  = 3 * LANES,
  localparam int PAT_W  = CHUNKS * CHUNK_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [AW-1:0]      cfg_addr_i,
  input  logic [31:0]        cfg_wdata_i,
  input  logic [LANES*W-1:0] link_data_i,
  output logic [LANES*W-1:0] lane_data_o
);
  logic [1:0]       mode_q, lane_cnt_q;
  logic [SEL_W-1:0] src_q, ord_q;
  logic [SQ_W-1:0]  width_q;
  logic [PAT_W-1:0] custom_q;

  link_pg_cfg #(
    .LANES(LANES), .AW(AW), .DW(32), .CHUNKS(CHUNKS),
    .CHUNK_W(CHUNK_W), .SQ_W(SQ_W), .CUST_BASE(16)
  ) cfg_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .mode_o(mode_q), .lane_cnt_o(lane_cnt_q), .src_o(src_q),
    .ord_o(ord_q), .width_o(width_q), .custom_o(custom_q)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [W-1:0] gen_word, nxt;

    link_pg_lane #(.W(W), .PAT_W(PAT_W), .SQ_W(SQ_W)) lane_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(cfg_we_i),
      .src_i(src_q[3*l +: 3]), .ord_i(ord_q[3*l +: 3]),
      .width_i(width_q), .custom_i(custom_q), .word_o(gen_word)
    );

    always_comb begin
      case (mode_q)
        MODE_ACTIVE: nxt = link_data_i[l*W +: W];
        MODE_TRN_A:  nxt = TRN_A_WORD;
        MODE_TRN_B:  nxt = TRN_B_WORD;
        default:     nxt = gen_word;
      endcase
      if (int'(lane_cnt_q) < l) nxt = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_data_o[l*W +: W] <= '0;
      else         lane_data_o[l*W +: W] <= nxt;
    end
  end
endmodule

// File: rtl/link_pattern_gen_chk.sv
module link_pattern_gen_chk
  import link_pg_pkg::*;
#(
  parameter int LANES = 4,
  parameter int W     = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         mode_q,
  input logic [1:0]         lane_cnt_q,
  input logic [3*LANES-1:0] src_q,
  input logic [LANES*W-1:0] link_data_i,
  input logic [LANES*W-1:0] lane_data_o
);
  assert_pass_through_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_ACTIVE) |=> (lane_data_o[W-1:0] == $past(link_data_i[W-1:0])));

  assert_train_a_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_TRN_A) |=> (lane_data_o[W-1:0] == TRN_A_WORD));

  assert_bad_src_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_TEST && src_q[2:0] > 3'd4) |=> (lane_data_o[W-1:0] == '0));

  assert_idle_lanes_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_cnt_q == 2'd0) |=> (lane_data_o[LANES*W-1:W] == '0));
endmodule

bind link_pattern_gen link_pattern_gen_chk #(.LANES(LANES), .W(W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_q(mode_q), .lane_cnt_q(lane_cnt_q),
  .src_q(src_q), .link_data_i(link_data_i), .lane_data_o(lane_data_o)
);

// File: tb/link_pattern_gen_tb.sv
module link_pattern_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int LANES = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [4:0]       cfg_addr_i = '0;
  logic [31:0]      cfg_wdata_i = '0;
  logic [LANES*W-1:0] link_data_i = '0;
  logic [LANES*W-1:0] lane_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  link_pattern_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .link_data_i(link_data_i), .lane_data_o(lane_data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane(input int l);
    return lane_data_o[l*W +: W];
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  function automatic logic [31:0] mk_sel(input int s0, s1, s2, s3, o0, o1, o2, o3);
    return 32'(s0 | s1 << 3 | s2 << 6 | s3 << 9 |
               (o0 | o1 << 3 | o2 << 6 | o3 << 9) << 12);
  endfunction

  function automatic logic [31:0] m_prbs(input int ord, inout logic [30:0] s);
    int n, t;
    logic fb;
    logic [31:0] w;
    case (ord)
      1: begin n = 9;  t = 5;  end
      2: begin n = 11; t = 9;  end
      3: begin n = 15; t = 14; end
      4: begin n = 23; t = 18; end
      5: begin n = 31; t = 28; end
      default: begin n = 7; t = 6; end
    endcase
    for (int b = 0; b < 32; b++) begin
      fb = s[n-1] ^ s[t-1];
      w[b] = fb;
      s = {s[29:0], fb};
    end
    return w;
  endfunction

  task automatic t_reset();
    for (int l = 0; l < LANES; l++) chk("R1 reset output", lane(l), 32'h0);
  endtask

  task automatic t_active();
    wr(5'd0, 32'h30);
    @(negedge clk_i);
    link_data_i = {32'hDDDD0003, 32'hCCCC0002, 32'hBBBB0001, 32'hAAAA0000};
    @(negedge clk_i);
    for (int l = 0; l < LANES; l++) chk("R3 pass-through", lane(l), link_data_i[l*W +: W]);
    wr(5'd0, 32'h00);
    link_data_i = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111};
    @(negedge clk_i);
    chk("R2 one lane live", lane(0), 32'h11111111);
    for (int l = 1; l < LANES; l++) chk("R10 idle lane zero", lane(l), 32'h0);
  endtask

  task automatic t_training();
    wr(5'd0, 32'h11);
    @(negedge clk_i);
    chk("R4 word A lane0", lane(0), 32'h55555555);
    chk("R4 word A lane1", lane(1), 32'h55555555);
    chk("R10 lane2 zero", lane(2), 32'h0);
    chk("R10 lane3 zero", lane(3), 32'h0);
    wr(5'd0, 32'h32);
    @(negedge clk_i);
    for (int l = 0; l < LANES; l++) chk("R4 word B", lane(l), 32'h3C3C3C3C);
  endtask

  task automatic t_prbs(input int o0, o1, o2, o3);
    logic [30:0] st [LANES];
    int ord [LANES];
    ord[0] = o0; ord[1] = o1; ord[2] = o2; ord[3] = o3;
    for (int l = 0; l < LANES; l++) st[l] = '1;
    wr(5'd1, mk_sel(2, 2, 2, 2, o0, o1, o2, o3));
    wr(5'd0, 32'h33);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      for (int l = 0; l < LANES; l++) chk("R6 prbs word", lane(l), m_prbs(ord[l], st[l]));
    end
  endtask

  task automatic t_custom();
    logic [263:0] pat;
    logic [7:0] by;
    logic [31:0] exp;
    for (int i = 0; i < 11; i++) begin
      logic [23:0] ch;
      for (int j = 0; j < 3; j++) begin
        by = 8'((3*i + j) * 37 + 11);
        ch[j*8 +: 8] = by;
      end
      pat[i*24 +: 24] = ch;
      wr(5'(16 + i), {8'hEE, ch});
    end
    wr(5'd1, mk_sel(3, 3, 5, 7, 0, 0, 0, 0));
    wr(5'd0, 32'h33);
    for (int n = 0; n < 12; n++) begin
      @(negedge clk_i);
      for (int b = 0; b < 32; b++) exp[b] = pat[(32*n + b) % 264];
      chk("R7 custom word", lane(0), exp);
      chk("R7 custom lane1", lane(1), exp);
      chk("R5 src code 5 zero", lane(2), 32'h0);
      chk("R5 src code 7 zero", lane(3), 32'h0);
    end
  endtask

  task automatic t_square();
    wr(5'd2, 32'h3);
    wr(5'd1, mk_sel(4, 0, 1, 4, 0, 0, 0, 0));
    wr(5'd0, 32'h33);
    for (int n = 0; n < 13; n++) begin
      @(negedge clk_i);
      chk("R8 square w3", lane(0), (n % 6 < 3) ? 32'hFFFFFFFF : 32'h0);
      chk("R5 src word A", lane(1), 32'h55555555);
      chk("R5 src word B", lane(2), 32'h3C3C3C3C);
    end
    wr(5'd2, 32'h0);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk_i);
      chk("R8 square w0 as 1", lane(3), (n % 2 == 0) ? 32'hFFFFFFFF : 32'h0);
    end
  endtask

  task automatic t_restart();
    logic [30:0] s;
    logic [31:0] first;
    s = '1;
    first = m_prbs(0, s);
    wr(5'd1, mk_sel(2, 0, 0, 0, 6, 0, 0, 0));
    wr(5'd0, 32'h03);
    @(negedge clk_i);
    chk("R5 order 6 as prbs7", lane(0), first);
    repeat (5) @(negedge clk_i);
    wr(5'd2, 32'h9);
    @(negedge clk_i);
    chk("R9 restart on write", lane(0), first);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_active();
    t_training();
    t_prbs(0, 5, 3, 4);
    t_prbs(1, 2, 0, 5);
    t_custom();
    t_square();
    t_restart();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule